// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block is the arithmetic core of a 32-bit integer datapath. Each cycle in which `valid_i` is high, it takes two operands, an incoming carry bit and a 4-bit operation code. On the next rising clock edge it registers a result, a one-cycle write-enable for that result, and six status flags.

The operations are addition, subtraction and comparison, with and without carry or borrow, plus negation, increment, decrement and two sign-extension moves. All of the flag-producing operations go through one shared add/subtract engine and one result-flag generator. Operand fetch, addressing, decode and exception handling belong to the surrounding pipeline.

The flags are held in a register, so they persist between operations. Operations that leave some or all flags untouched simply keep the held values.

Top module: `alu_flagcore`

## Requirements
- R1: Op code 0 (add) gives `a+b`, and op code 1 (add with carry) gives `a+b+carry_i`. CF (flags bit 0) is the carry out of bit 31, and the result is written.
- R2: Op code 2 (subtract) gives `a-b`, and op code 3 (subtract with borrow) gives `a-(b+carry_i)`. CF is set when a borrow out of bit 31 occurs.
- R3: Op code 4 (compare) sets all six flags exactly as subtract would. `wr_en_o` stays low and `result_o` keeps its previous value.
- R4: Op code 5 (negate) gives `0-a` with all flags as for a subtraction from zero. So CF is set exactly when `a` is nonzero, and OF is set only for `a`=0x80000000.
- R5: Op code 6 (increment) gives `a+1` and op code 7 (decrement) gives `a-1`. CF keeps its previous value, and the other five flags follow the operation.
- R6: Op code 8 (halfword sign extension) writes bit 15 of `a` into bits 31:16 and keeps bits 15:0. All flags stay unchanged.
- R7: Op code 9 (high-word extension) writes all ones when bit 31 of `a` is set and all zeros otherwise. All flags stay unchanged.
- R8: `flags_o` is {OF,SF,ZF,AF,PF,CF}, running from bit 5 down to bit 0.
  - ZF is set when the result is zero, and SF is result bit 31.
  - PF is set when result bits 7:0 hold an even number of ones.
  - AF is the carry or borrow out of bit 3.
  - OF on add is set when the operands have equal signs and the result sign differs from them. On subtract it is set when the operand signs differ and the result sign differs from the minuend's.
- R9: Outputs change only on a clock edge with `valid_i` high. After a cycle with `valid_i` low, `wr_en_o` is low and the result and flags are held.
- R10: A synchronous reset clears the flags, the result and `wr_en_o`.
- R11: Op codes 10 to 15 write no result and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand (minuend, single operand) |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry/borrow input for the chained ops |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Result write-enable, one cycle per writing op |
| flags_o | output | 6 | Registered {OF,SF,ZF,AF,PF,CF} |

## Verification
Random operands across all sixteen op codes exercise carry and borrow in both polarities, and random idle cycles check that held state is kept. Directed vectors cover the arithmetic edge cases:
- signed wrap at 0x7FFFFFFF and 0x80000000, which separates the OF rule from the CF rule;
- unsigned wrap at all ones and at zero, which tests CF and ZF;
- negation of zero and of the most negative value;
- low-nibble patterns that isolate AF;
- equal-operand compares.

Sign-extension vectors with each sign bit set and clear check that those ops preserve the flags. Increment and decrement are run with CF preset both ways to check that CF is preserved.

// File: rtl/alu_flagcore_pkg.sv
package alu_flagcore_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_NEG  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_SXH  = 4'd8,
        OP_SXW  = 4'd9
    } op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_c,
    output logic         ovf
);
    localparam int unsigned EW = W + 1;

    logic [W:0] ext;

    always_comb begin
        if (sub) begin
            ext = {1'b0, a} - {1'b0, b} - EW'(cin);
        end else begin
            ext = {1'b0, a} + {1'b0, b} + EW'(cin);
        end
    end

    assign sum    = ext[W-1:0];
    assign cout   = ext[W];
    assign half_c = a[4] ^ b[4] ^ ext[4];
    assign ovf    = sub ? ((a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]))
                        : (~(a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]));

endmodule

// File: rtl/alu_resflags.sv
module alu_resflags #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] res,
    output logic         zro,
    output logic         sgn,
    output logic         par
);
    assign zro = (res == '0);
    assign sgn = res[W-1];
    assign par = ~^res[7:0];
endmodule

// File: rtl/alu_flagcore.sv
module alu_flagcore
    import alu_flagcore_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [5:0]        flags_o
);
    localparam int unsigned HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        flags_t            flg;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [DATA_W-1:0] eng_a, eng_b, eng_sum;
    logic              eng_cin, eng_sub, eng_cout, eng_half, eng_ovf;
    logic              rf_zro, rf_sgn, rf_par;

    assign op = op_e'(op_i);

    // operand steering into the shared engine
    always_comb begin
        eng_a   = a_i;
        eng_b   = b_i;
        eng_cin = 1'b0;
        eng_sub = 1'b0;
        case (op)
            OP_ADC: eng_cin = carry_i;
            OP_SUB: eng_sub = 1'b1;
            OP_SBB: begin eng_sub = 1'b1; eng_cin = carry_i; end
            OP_CMP: eng_sub = 1'b1;
            OP_NEG: begin eng_a = '0; eng_b = a_i; eng_sub = 1'b1; end
            OP_INC: eng_b = DATA_W'(1);
            OP_DEC: begin eng_b = DATA_W'(1); eng_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_eng (
        .a      (eng_a),
        .b      (eng_b),
        .cin    (eng_cin),
        .sub    (eng_sub),
        .sum    (eng_sum),
        .cout   (eng_cout),
        .half_c (eng_half),
        .ovf    (eng_ovf)
    );

    alu_resflags #(.W(DATA_W)) u_rf (
        .res (eng_sum),
        .zro (rf_zro),
        .sgn (rf_sgn),
        .par (rf_par)
    );

    always_comb begin
        flags_t f;
        st_d    = st_q;
        st_d.wr = 1'b0;
        f.ovf   = eng_ovf;
        f.sgn   = rf_sgn;
        f.zro   = rf_zro;
        f.aux   = eng_half;
        f.par   = rf_par;
        f.cry   = eng_cout;
        if (valid_i) begin
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: begin
                    st_d.res = eng_sum;
                    st_d.wr  = 1'b1;
                    st_d.flg = f;
                end
                OP_CMP: begin
                    st_d.flg = f;
                end
                OP_INC, OP_DEC: begin
                    st_d.res = eng_sum;
                    st_d.wr  = 1'b1;
                    f.cry    = st_q.flg.cry;
                    st_d.flg = f;
                end
                OP_SXH: begin
                    st_d.res = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
                    st_d.wr  = 1'b1;
                end
                OP_SXW: begin
                    st_d.res = {DATA_W{a_i[DATA_W-1]}};
                    st_d.wr  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign wr_en_o  = st_q.wr;
    assign flags_o  = st_q.flg;

    // compare never writes
    assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_CMP) |=> !wr_en_o);

    // negate: carry exactly when the operand was nonzero
    assert_neg_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_NEG) |=> (flags_o[0] == ($past(a_i) != '0)));

    // inc/dec keep carry
    assert_incdec_cf_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_o[0])));

    // sign extensions keep every flag
    assert_ext_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == OP_SXH || op_i == OP_SXW)) |=> $stable(flags_o));

    // high-word extension result
    assert_sxw_value_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_SXW) |=> (result_o == {DATA_W{$past(a_i[DATA_W-1])}}));

    // idle cycles hold state
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!wr_en_o && $stable(flags_o) && $stable(result_o)));

    // unused codes do nothing
    assert_unused_op_R11: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i >= 4'd10) |=> (!wr_en_o && $stable(flags_o)));

endmodule

// File: tb/alu_flagcore_tb.sv
module alu_flagcore_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [5:0]  flags_o;

    always #2.5 clk = ~clk;

    alu_flagcore u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_res;
    logic [5:0]  m_flg;

    function automatic bit par8(input logic [31:0] r);
        int c = 0;
        for (int i = 0; i < 8; i++) c += r[i];
        return (c % 2) == 0;
    endfunction

    // arithmetic flags {OF,SF,ZF,AF,PF,CF} for a+b+c or a-(b+c)
    function automatic logic [37:0] arith(input logic [31:0] a, input logic [31:0] b,
                                          input bit c, input bit sub);
        logic [31:0] r;
        logic [32:0] wide;
        logic [4:0]  nib;
        longint      s;
        bit o, af, cf;
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {32'd0, c};
            nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, c};
            s    = longint'($signed(a)) - longint'($signed(b)) - longint'(c);
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {32'd0, c};
            nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, c};
            s    = longint'($signed(a)) + longint'($signed(b)) + longint'(c);
        end
        r  = wide[31:0];
        cf = wide[32];
        af = nib[4];
        o  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return {r, o, r[31], (r == 0), af, par8(r), cf};
    endfunction

    task automatic expect_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input bit c, output logic [31:0] er, output bit ew,
                             output logic [5:0] ef, output string tag);
        logic [37:0] t;
        er = m_res; ew = 0; ef = m_flg; tag = "R11";
        case (op)
            4'd0: begin t = arith(a, b, 0, 0); er = t[37:6]; ew = 1; ef = t[5:0]; tag = "R1"; end
            4'd1: begin t = arith(a, b, c, 0); er = t[37:6]; ew = 1; ef = t[5:0]; tag = "R1"; end
            4'd2: begin t = arith(a, b, 0, 1); er = t[37:6]; ew = 1; ef = t[5:0]; tag = "R2"; end
            4'd3: begin t = arith(a, b, c, 1); er = t[37:6]; ew = 1; ef = t[5:0]; tag = "R2"; end
            4'd4: begin t = arith(a, b, 0, 1); ef = t[5:0]; tag = "R3"; end
            4'd5: begin t = arith(0, a, 0, 1); er = t[37:6]; ew = 1; ef = t[5:0]; tag = "R4"; end
            4'd6: begin t = arith(a, 1, 0, 0); er = t[37:6]; ew = 1; ef = {t[5:1], m_flg[0]}; tag = "R5"; end
            4'd7: begin t = arith(a, 1, 0, 1); er = t[37:6]; ew = 1; ef = {t[5:1], m_flg[0]}; tag = "R5"; end
            4'd8: begin er = {{16{a[15]}}, a[15:0]}; ew = 1; tag = "R6"; end
            4'd9: begin er = a[31] ? 32'hFFFF_FFFF : 32'h0; ew = 1; tag = "R7"; end
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] er, input bit ew, input logic [5:0] ef);
        n_chk++;
        if (result_o !== er || wr_en_o !== ew || flags_o !== ef) begin
            n_fail++;
            $display("FAIL %s/R8 res=%h exp %h wr=%b exp %b flags=%b exp %b",
                     tag, result_o, er, wr_en_o, ew, flags_o, ef);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input bit c);
        logic [31:0] er; bit ew; logic [5:0] ef; string tag;
        expect_op(op, a, b, c, er, ew, ef, tag);
        valid_i = 1; op_i = op; a_i = a; b_i = b; carry_i = c;
        @(negedge clk);
        check(tag, er, ew, ef);
        m_res = er; m_flg = ef;
    endtask

    task automatic idle();
        valid_i = 0; op_i = 4'($urandom); a_i = $urandom; b_i = $urandom; carry_i = 1'($urandom);
        @(negedge clk);
        check("R9", m_res, 0, m_flg);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'h0000_000F;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        valid_i = 1; op_i = 4'd0; a_i = 32'hFFFF_FFFF; b_i = 32'h1;
        repeat (3) @(negedge clk);
        rst = 0; valid_i = 0;
        m_res = 0; m_flg = 0;
        check("R10", 32'h0, 0, 6'h0);

        // directed corners
        run(4'd0, 32'h7FFF_FFFF, 32'h1, 0);
        run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
        run(4'd1, 32'hFFFF_FFFE, 32'h1, 1);
        run(4'd2, 32'h0, 32'h1, 0);
        run(4'd2, 32'h8000_0000, 32'h1, 0);
        run(4'd3, 32'h5, 32'h5, 1);
        run(4'd4, 32'h1234_5678, 32'h1234_5678, 0);
        run(4'd5, 32'h0, 32'h0, 0);
        run(4'd5, 32'h8000_0000, 32'h0, 0);
        run(4'd0, 32'h0000_0008, 32'h0000_0008, 0);
        run(4'd6, 32'hFFFF_FFFF, 32'h0, 0);
        run(4'd7, 32'h0, 32'h0, 0);
        run(4'd2, 32'h0, 32'h1, 0);
        run(4'd6, 32'h7FFF_FFFF, 32'h0, 0);
        run(4'd8, 32'h0000_8000, 32'h0, 0);
        run(4'd8, 32'hFFFF_7FFF, 32'h0, 0);
        run(4'd9, 32'h8000_0000, 32'h0, 0);
        run(4'd9, 32'h7FFF_FFFF, 32'h0, 0);
        run(4'd12, 32'h1, 32'h2, 1);
        idle();

        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 8 == 0) idle();
            else run(4'($urandom), pick(), pick(), 1'($urandom));
        end

        // reset mid-run clears state
        rst = 1; valid_i = 1; op_i = 4'd0; a_i = 32'h1; b_i = 32'h1;
        @(negedge clk);
        rst = 0; valid_i = 0;
        m_res = 0; m_flg = 0;
        check("R10", 32'h0, 0, 6'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R9 res=%h exp done flags=%b", result_o, flags_o);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule